// File: doc/BRIEF.md
# Initiator Bus Control Register

This block is the initiator-side control and status register of a parallel SCSI bus controller. The CPU writes one byte that sets or releases the ATN, SEL, BSY, ACK and RST lines. The same byte enables the data bus drivers and can place every driver in a released test state. Because ATN and SEL sit in the same byte, one write can begin a selection with attention raised.

A read of the same location returns the line bits that were last written. Two bit positions have a different meaning on read: there they return arbitration status. A small monitor watches the received BSY and SEL lines. While the arbitrate input is held, the monitor waits for the bus to be free, then drives BSY and the output data byte, and records whether another device took the bus by raising SEL.

Outputs to the bus are modelled as separate assert signals. Inputs from the bus are modelled as separate receive signals.

Top module: `initiator_ctl_reg`

## Requirements
- R1: A write stores wr_data in the register, and it takes effect from the next clock edge. The bits are: bit0 data-bus enable, bit1 ATN, bit2 SEL, bit3 BSY, bit4 ACK, bit5 reserved (stored as zero), bit6 test mode, bit7 RST. On read, rd_data bits 0-4 and bit 7 return the stored values, and a 1 written to bit 5 has no effect.
- R2: A synchronous reset clears every control bit and both status flags. After reset, rd_data is 0 and every drive output is 0.
- R3: drv_atn and drv_ack follow their control bits only while target_mode is 0. While target_mode is 1, both are 0.
- R4: drv_sel follows the SEL bit. A single write of 0x06 raises drv_sel and drv_atn in the same cycle.
- R5: drv_db_en is 1 when either of two conditions holds. The first condition needs all of these: the enable bit is set, target_mode is 0, rx_phase[1] (received I/O) is 0, and rx_phase equals exp_phase, with both ordered {C/D, I/O, MSG} from bit 2 down to bit 0. The second condition is that arbitration is in progress. While drv_db_en is 1, drv_db equals out_data; otherwise drv_db is 0.
- R6: While the data bus is driven, drv_dbp makes the nine bits {drv_dbp, drv_db} odd in ones count. Otherwise drv_dbp is 0.
- R7: While the test mode bit is 1, every drive output is 0. drv_rst follows the RST bit only outside test mode. Clearing test mode restores normal driving.
- R8: The bus counts as free once rx_bsy and rx_sel have both been 0 on FREE_CYCLES consecutive clock edges. If arb_req is 1, arbitration-in-progress is set on the edge that follows. While the flag is set, drv_bsy is asserted and out_data is driven.
- R9: Arbitration-in-progress reads on rd_data bit 6. It stays set while arb_req stays 1, and it clears on the first edge where arb_req is 0.
- R10: Lost-arbitration reads on rd_data bit 5. It is set on the edge after rx_sel is seen at 1 while arbitration is in progress. It stays set until the first edge where arb_req is 0.
- R11: drv_bsy follows the BSY bit outside arbitration. Writing the BSY bit back to 0 releases BSY, which disconnects from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write byte |
| rd_data | output | 8 | CPU read byte |
| target_mode | input | 1 | Controller is operating as target |
| exp_phase | input | 3 | Expected phase {C/D, I/O, MSG} from the target command register |
| arb_req | input | 1 | Arbitrate request |
| out_data | input | 8 | Output data byte (own ID during arbitration) |
| rx_bsy | input | 1 | Received BSY |
| rx_sel | input | 1 | Received SEL |
| rx_phase | input | 3 | Received {C/D, I/O, MSG} |
| drv_atn | output | 1 | Assert ATN |
| drv_sel | output | 1 | Assert SEL |
| drv_bsy | output | 1 | Assert BSY |
| drv_ack | output | 1 | Assert ACK |
| drv_rst | output | 1 | Assert RST |
| drv_db_en | output | 1 | Data bus driver enable |
| drv_db | output | 8 | Data bus byte |
| drv_dbp | output | 1 | Data bus parity |

## Verification
Register contents and both status flags are registered. A write is visible on rd_data and on the drive lines one clock edge after the strobe. Arbitration-in-progress appears one edge after the bus-free count completes, and lost-arbitration appears one edge after SEL is seen. Drive outputs depend combinationally on the stored state and on the current bus and mode inputs. The bench therefore changes inputs just after a falling edge, lets exactly one rising edge pass, and compares every output against a bench model at the next falling edge.

// File: rtl/scsi_icr_pkg.sv
package scsi_icr_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned PHASE_W = 3;

    // Register layout, bit 7 down to bit 0
    typedef struct packed {
        logic rst_line;
        logic test;
        logic rsvd;
        logic ack;
        logic bsy;
        logic sel;
        logic atn;
        logic db_on;
    } icr_ctrl_t;

    typedef struct packed {
        logic atn;
        logic sel;
        logic bsy;
        logic ack;
        logic rst_line;
        logic db_en;
    } line_drv_t;

    // Phase bits ordered {C/D, I/O, MSG}
    localparam int unsigned PH_IO = 1;

    function automatic logic odd_par(input logic [BYTE_W-1:0] d);
        return ~(^d);
    endfunction

    function automatic icr_ctrl_t ctrl_from_byte(input logic [BYTE_W-1:0] b);
        icr_ctrl_t c;
        c      = icr_ctrl_t'(b);
        c.rsvd = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/icr_regfile.sv
module icr_regfile
    import scsi_icr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output icr_ctrl_t         ctrl
);

    icr_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_from_byte(wr_data);
        end
    end

    assign ctrl = ctrl_q;

    // R1
    write_takes_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl.atn == $past(wr_data[1])) && (ctrl.rst_line == $past(wr_data[7]))
                  && !ctrl.rsvd);

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctrl == '0));

endmodule

// File: rtl/icr_arb_monitor.sv
module icr_arb_monitor #(
    parameter int unsigned FREE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arb_req,
    input  logic rx_bsy,
    input  logic rx_sel,
    output logic aip,
    output logic lost
);

    localparam int unsigned CNT_W = $clog2(FREE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FREE_CYCLES);

    logic [CNT_W-1:0] idle_cnt;
    logic             bus_free;
    logic             aip_q;
    logic             lost_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
        end else if (rx_bsy || rx_sel) begin
            idle_cnt <= '0;
        end else if (idle_cnt != CNT_MAX) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign bus_free = (idle_cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            aip_q  <= 1'b0;
            lost_q <= 1'b0;
        end else if (!arb_req) begin
            aip_q  <= 1'b0;
            lost_q <= 1'b0;
        end else begin
            if (bus_free) begin
                aip_q <= 1'b1;
            end
            if (aip_q && rx_sel) begin
                lost_q <= 1'b1;
            end
        end
    end

    assign aip  = aip_q;
    assign lost = lost_q;

    // R9
    arb_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !arb_req |=> (!aip && !lost));

    // R10
    lost_needs_aip_chk: assert property (@(posedge clk) disable iff (rst)
        lost |-> aip);

    // R8
    aip_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(aip) |-> ($past(bus_free) && $past(arb_req)));

endmodule

// File: rtl/icr_bus_gate.sv
module icr_bus_gate
    import scsi_icr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  icr_ctrl_t          ctrl,
    input  logic               target_mode,
    input  logic [PHASE_W-1:0] exp_phase,
    input  logic [PHASE_W-1:0] rx_phase,
    input  logic               aip,
    input  logic [BYTE_W-1:0]  out_data,
    output line_drv_t          lines,
    output logic [BYTE_W-1:0]  db,
    output logic               dbp
);

    logic      phase_ok;
    logic      init_db;
    line_drv_t raw;

    assign phase_ok = (rx_phase == exp_phase) && !rx_phase[PH_IO];
    assign init_db  = ctrl.db_on && !target_mode && phase_ok;

    always_comb begin
        raw.atn      = ctrl.atn && !target_mode;
        raw.ack      = ctrl.ack && !target_mode;
        raw.sel      = ctrl.sel;
        raw.bsy      = ctrl.bsy || aip;
        raw.rst_line = ctrl.rst_line;
        raw.db_en    = init_db || aip;
        lines        = ctrl.test ? '0 : raw;
    end

    assign db  = lines.db_en ? out_data : '0;
    assign dbp = lines.db_en ? odd_par(out_data) : 1'b0;

    // R7
    test_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.test |-> (lines == '0 && db == '0 && !dbp));

    // R6
    parity_odd_chk: assert property (@(posedge clk) disable iff (rst)
        lines.db_en |-> ($countones({dbp, db}) % 2 == 1));

    // R3
    target_block_chk: assert property (@(posedge clk) disable iff (rst)
        target_mode |-> (!lines.atn && !lines.ack));

endmodule

// File: rtl/initiator_ctl_reg.sv
module initiator_ctl_reg
    import scsi_icr_pkg::*;
#(
    parameter int unsigned FREE_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        target_mode,
    input  logic [2:0]  exp_phase,
    input  logic        arb_req,
    input  logic [7:0]  out_data,
    input  logic        rx_bsy,
    input  logic        rx_sel,
    input  logic [2:0]  rx_phase,
    output logic        drv_atn,
    output logic        drv_sel,
    output logic        drv_bsy,
    output logic        drv_ack,
    output logic        drv_rst,
    output logic        drv_db_en,
    output logic [7:0]  drv_db,
    output logic        drv_dbp
);

    icr_ctrl_t ctrl;
    line_drv_t lines;
    logic      aip;
    logic      lost;

    icr_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    icr_arb_monitor #(.FREE_CYCLES(FREE_CYCLES)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .arb_req (arb_req),
        .rx_bsy  (rx_bsy),
        .rx_sel  (rx_sel),
        .aip     (aip),
        .lost    (lost)
    );

    icr_bus_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .target_mode (target_mode),
        .exp_phase   (exp_phase),
        .rx_phase    (rx_phase),
        .aip         (aip),
        .out_data    (out_data),
        .lines       (lines),
        .db          (drv_db),
        .dbp         (drv_dbp)
    );

    // Read view: status flags replace the reserved and test positions
    always_comb begin
        rd_data    = ctrl;
        rd_data[5] = lost;
        rd_data[6] = aip;
    end

    assign drv_atn   = lines.atn;
    assign drv_sel   = lines.sel;
    assign drv_bsy   = lines.bsy;
    assign drv_ack   = lines.ack;
    assign drv_rst   = lines.rst_line;
    assign drv_db_en = lines.db_en;

    // R8
    arb_drives_chk: assert property (@(posedge clk) disable iff (rst)
        (aip && !ctrl.test) |-> (drv_bsy && drv_db_en && drv_db == out_data));

endmodule

// File: tb/test_initiator_ctl_reg.sv
`timescale 1ns/1ps
module test_initiator_ctl_reg;

    localparam int unsigned FREE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       target_mode = 1'b0;
    logic [2:0] exp_phase = '0;
    logic       arb_req = 1'b0;
    logic [7:0] out_data = 8'h5A;
    logic       rx_bsy = 1'b1;
    logic       rx_sel = 1'b0;
    logic [2:0] rx_phase = '0;
    logic       drv_atn, drv_sel, drv_bsy, drv_ack, drv_rst, drv_db_en, drv_dbp;
    logic [7:0] drv_db;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    initiator_ctl_reg #(.FREE_CYCLES(FREE)) i_initiator_ctl_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .target_mode(target_mode), .exp_phase(exp_phase), .arb_req(arb_req),
        .out_data(out_data), .rx_bsy(rx_bsy), .rx_sel(rx_sel), .rx_phase(rx_phase),
        .drv_atn(drv_atn), .drv_sel(drv_sel), .drv_bsy(drv_bsy), .drv_ack(drv_ack),
        .drv_rst(drv_rst), .drv_db_en(drv_db_en), .drv_db(drv_db), .drv_dbp(drv_dbp)
    );

    // Bench model of the stored state
    logic [7:0] m_ctrl = '0;
    int         m_cnt  = 0;
    logic       m_aip  = 1'b0;
    logic       m_lost = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl <= '0; m_cnt <= 0; m_aip <= 1'b0; m_lost <= 1'b0;
        end else begin
            if (wr_en) m_ctrl <= wr_data & 8'hDF;
            if (rx_bsy || rx_sel) m_cnt <= 0;
            else if (m_cnt < FREE) m_cnt <= m_cnt + 1;
            if (!arb_req) begin
                m_aip <= 1'b0; m_lost <= 1'b0;
            end else begin
                if (m_cnt == FREE) m_aip <= 1'b1;
                if (m_aip && rx_sel) m_lost <= 1'b1;
            end
        end
    end

    function automatic logic exp_den();
        logic ok;
        ok = m_ctrl[0] && !target_mode && !rx_phase[1] && (rx_phase == exp_phase);
        return !m_ctrl[6] && (ok || m_aip);
    endfunction

    function automatic logic [7:0] exp_rd();
        return {m_ctrl[7], m_aip, m_lost, m_ctrl[4:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic t, den;
        logic [7:0] r;
        t   = m_ctrl[6];
        den = exp_den();
        r   = exp_rd();
        chk({rd_data[7], rd_data[4:0]} === {r[7], r[4:0]}, "R1 rd_data", rd_data, r);
        chk(rd_data[6] === r[6], "R9 aip flag", rd_data[6], r[6]);
        chk(rd_data[5] === r[5], "R10 lost flag", rd_data[5], r[5]);
        chk(drv_atn === (!t && m_ctrl[1] && !target_mode), "R3 atn", drv_atn, !t && m_ctrl[1] && !target_mode);
        chk(drv_ack === (!t && m_ctrl[4] && !target_mode), "R3 ack", drv_ack, !t && m_ctrl[4] && !target_mode);
        chk(drv_sel === (!t && m_ctrl[2]), "R4 sel", drv_sel, !t && m_ctrl[2]);
        chk(drv_bsy === (!t && (m_ctrl[3] || m_aip)), "R11 bsy", drv_bsy, !t && (m_ctrl[3] || m_aip));
        chk(drv_rst === (!t && m_ctrl[7]), "R7 rst", drv_rst, !t && m_ctrl[7]);
        chk(drv_db_en === den, "R5 db_en", drv_db_en, den);
        chk(drv_db === (den ? out_data : 8'h00), "R5 db", drv_db, den ? out_data : 8'h00);
        chk(drv_dbp === (den ? ~(^out_data) : 1'b0), "R6 parity", drv_dbp, den ? ~(^out_data) : 1'b0);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic write_reg(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset state
        chk(rd_data === 8'h00, "R2 rd after reset", rd_data, 8'h00);
        chk({drv_atn, drv_sel, drv_bsy, drv_ack, drv_rst, drv_db_en, drv_dbp} === 7'b0 && drv_db === 8'h00,
            "R2 drives after reset", {drv_atn, drv_sel, drv_bsy, drv_ack, drv_rst, drv_db_en}, 0);

        // R4: one write raises SEL and ATN together
        write_reg(8'h06);
        chk(drv_sel === 1'b1 && drv_atn === 1'b1, "R4 sel+atn", {drv_sel, drv_atn}, 2'b11);

        // R3: target mode blocks ATN
        target_mode = 1'b1;
        tick();
        chk(drv_atn === 1'b0, "R3 atn blocked", drv_atn, 1'b0);
        target_mode = 1'b0;

        // R1: reserved bit ignored
        write_reg(8'h20);
        chk(rd_data[5] === 1'b0, "R1 reserved bit", rd_data[5], 1'b0);

        // R5/R6: data out in a matching data-out phase
        exp_phase = 3'b000; rx_phase = 3'b000; out_data = 8'h03;
        write_reg(8'h01);
        chk(drv_db_en === 1'b1 && drv_db === 8'h03 && drv_dbp === 1'b1, "R6 parity even byte",
            {drv_db_en, drv_db, drv_dbp}, {1'b1, 8'h03, 1'b1});
        rx_phase = 3'b010; exp_phase = 3'b010;
        tick();
        chk(drv_db_en === 1'b0, "R5 io blocks", drv_db_en, 1'b0);
        rx_phase = 3'b000; exp_phase = 3'b000;

        // R7: test mode silences everything, clearing restores
        write_reg(8'hDF);
        chk({drv_atn, drv_sel, drv_bsy, drv_ack, drv_rst, drv_db_en} === 6'b0, "R7 test quiet",
            {drv_atn, drv_sel, drv_bsy, drv_ack, drv_rst, drv_db_en}, 0);
        write_reg(8'h9F);
        chk(drv_rst === 1'b1 && drv_bsy === 1'b1, "R7 restored", {drv_rst, drv_bsy}, 2'b11);

        // R11: releasing BSY
        write_reg(8'h00);
        chk(drv_bsy === 1'b0, "R11 bsy released", drv_bsy, 1'b0);

        // R8: bus-free count then arbitration
        out_data = 8'h40; arb_req = 1'b1; rx_bsy = 1'b1; rx_sel = 1'b0;
        tick(); tick();
        rx_bsy = 1'b0;
        for (int i = 0; i < FREE; i++) tick();
        chk(rd_data[6] === 1'b0, "R8 aip not yet", rd_data[6], 1'b0);
        tick();
        chk(rd_data[6] === 1'b1 && drv_bsy === 1'b1 && drv_db === 8'h40, "R8 aip set",
            {rd_data[6], drv_bsy, drv_db}, {1'b1, 1'b1, 8'h40});

        // R10: SEL from another device
        rx_sel = 1'b1;
        tick();
        chk(rd_data[5] === 1'b1, "R10 lost set", rd_data[5], 1'b1);
        rx_sel = 1'b0;
        tick();
        chk(rd_data[6:5] === 2'b11, "R9 flags held", rd_data[6:5], 2'b11);

        // R9: dropping arb_req clears both
        arb_req = 1'b0;
        tick();
        chk(rd_data[6:5] === 2'b00, "R9 flags cleared", rd_data[6:5], 2'b00);

        // Random phase
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            wr_en       = ($urandom % 6) == 0;
            wr_data     = 8'($urandom);
            if (($urandom % 3) == 0) wr_data[6] = 1'b0;
            target_mode = ($urandom % 4) == 0;
            if (($urandom % 20) == 0) arb_req = ~arb_req;
            rx_bsy      = ($urandom % 5) == 0;
            rx_sel      = ($urandom % 6) == 0;
            exp_phase   = 3'($urandom);
            rx_phase    = (($urandom % 2) == 0) ? exp_phase : 3'($urandom);
            out_data    = 8'($urandom);
            if (($urandom % 200) == 0) rst = 1'b1;
            tick();
            rst = 1'b0;
        end
        wr_en = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule